// File: doc/BRIEF.md
# UART Receive Idle-Timeout Detector

This block sits beside a UART receiver and watches the receive line, one sample per bit time, for quiet periods. A quiet period is measured in idle characters: runs of consecutive ones exactly as long as one full character in the current frame format. After a data character has been received, the block counts the idle characters that follow. If the programmed number of them arrives before the next data character, it closes the current receive buffer with a one-cycle pulse and, if enabled, raises a one-cycle interrupt request. Software uses this to mark the end of a message on a line that has no framing of its own.

The character length comes from the format inputs: one start bit, seven or eight data bits, an optional address bit, an optional parity bit and one or two stop bits. This gives 9 to 13 bits. The timeout register is loaded into an internal down counter each time a data character arrives. A programmed zero stands for the largest count. Only one timeout fires per gap.

Top module: `uart_idle_timeout`

## Requirements
- R1: After reset, `close_o` and `irq_o` are low and detection is disarmed, so a line that stays high before the first `char_done` never produces a timeout.
- R2: An idle character is complete on the bit strobe that samples the Nth consecutive one, where N = 1 + (`data8` ? 8 : 7) + `addr_en` + `par_en` + (`stop2` ? 2 : 1).
- R3: A strobe that samples `rx_line` = 0 restarts the ones run, so the bits counted before it do not count toward an idle character.
- R4: A `char_done` pulse loads the down counter from `tmo_val`, arms detection and restarts the ones run. A new character in the middle of a gap therefore discards the idle characters already counted.
- R5: When the programmed number of idle characters has completed since the last `char_done`, `close_o` is high for exactly one cycle, in the cycle after the strobe that completed the last idle character. One idle character fewer produces no pulse.
- R6: `tmo_val` = 0 means 2^CNT_W idle characters. A value of 1 means one idle character.
- R7: After a timeout, detection stays disarmed until the next `char_done`, so a gap produces at most one `close_o` pulse however long it lasts.
- R8: `irq_o` pulses together with `close_o` when `irq_en` = 1 and stays low when `irq_en` = 0.
- R9: Cycles with `bit_stb` = 0 leave the ones run and the down counter unchanged, whatever the level of `rx_line`.
- R10: When `char_done` and `bit_stb` are high in the same cycle, `char_done` wins and the strobe's sample is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | High for one cycle per bit time; `rx_line` is sampled then |
| rx_line | input | 1 | Receive line level |
| char_done | input | 1 | One-cycle pulse per received data character |
| data8 | input | 1 | 1 = eight data bits, 0 = seven |
| addr_en | input | 1 | 1 = frame carries an address bit |
| par_en | input | 1 | 1 = frame carries a parity bit |
| stop2 | input | 1 | 1 = two stop bits, 0 = one |
| tmo_val | input | CNT_W | Idle characters before timeout; 0 means 2^CNT_W |
| irq_en | input | 1 | Enables the interrupt pulse |
| close_o | output | 1 | One-cycle buffer-close pulse |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
The bench builds the block with CNT_W = 8 instead of the default 16. With this width, the zero-means-maximum case (256 idle characters of 9 bits) fits in a short run, and the counter's wrap from zero is exercised end to end. The frame format is switched between 9, 11 and 13 bit characters. This puts both ends of the length range and a middle value within reach, as well as the off-by-one boundary of each count.

// File: rtl/uart_idle_pkg.sv
package uart_idle_pkg;
  localparam int unsigned LEN_W = 4;

  typedef struct packed {
    logic data8;
    logic addr_en;
    logic par_en;
    logic stop2;
  } frame_fmt_t;

  // Bits per character: start + data + optional address + optional parity + stop
  function automatic logic [LEN_W-1:0] char_bits(input frame_fmt_t f);
    logic [LEN_W-1:0] n;
    n = LEN_W'(1);
    n = n + (f.data8 ? LEN_W'(8) : LEN_W'(7));
    n = n + LEN_W'(f.addr_en);
    n = n + LEN_W'(f.par_en);
    n = n + (f.stop2 ? LEN_W'(2) : LEN_W'(1));
    return n;
  endfunction
endpackage

// File: rtl/idle_run_cnt.sv
module idle_run_cnt #(
  parameter int unsigned LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             rx_line,
  input  logic             restart,
  input  logic [LEN_W-1:0] len,
  output logic             idle_char
);
  logic [LEN_W-1:0] run_q, run_d;
  logic [LEN_W-1:0] run_inc;

  assign run_inc = run_q + LEN_W'(1);

  always_comb begin
    run_d     = run_q;
    idle_char = 1'b0;
    if (restart) begin
      run_d = '0;
    end else if (bit_stb) begin
      if (!rx_line) begin
        run_d = '0;
      end else if (run_inc >= len) begin
        run_d     = '0;
        idle_char = 1'b1;
      end else begin
        run_d = run_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assert_zero_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !rx_line && !restart) |=> (run_q == '0));
  assert_restart_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (run_q == '0));
  assert_hold_no_stb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_stb && !restart) |=> $stable(run_q));
  assert_run_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idle_char |=> (run_q == '0));
endmodule

// File: rtl/idle_tmo_cnt.sv
module idle_tmo_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             idle_char,
  output logic             fire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             cnt_en;

  assign cnt_en = idle_char && armed_q && !load;
  assign fire   = cnt_en && (cnt_q == ONE);

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (load) begin
      cnt_d   = load_val;
      armed_d = 1'b1;
    end else if (cnt_en) begin
      cnt_d = cnt_q - ONE;
      if (cnt_q == ONE) armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (armed_q && cnt_q == $past(load_val)));
  assert_disarm_after_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !armed_q);
  assert_stay_disarmed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !load) |=> !armed_q);
  assert_hold_no_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_char && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/uart_idle_timeout.sv
module uart_idle_timeout
  import uart_idle_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             rx_line,
  input  logic             char_done,
  input  logic             data8,
  input  logic             addr_en,
  input  logic             par_en,
  input  logic             stop2,
  input  logic [CNT_W-1:0] tmo_val,
  input  logic             irq_en,
  output logic             close_o,
  output logic             irq_o
);
  frame_fmt_t       fmt;
  logic [LEN_W-1:0] len;
  logic             idle_char;
  logic             fire;
  logic             close_q, close_d;
  logic             irq_q, irq_d;

  assign fmt = '{data8: data8, addr_en: addr_en, par_en: par_en, stop2: stop2};
  assign len = char_bits(fmt);

  idle_run_cnt #(.LEN_W(LEN_W)) u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb   (bit_stb),
    .rx_line   (rx_line),
    .restart   (char_done),
    .len       (len),
    .idle_char (idle_char)
  );

  idle_tmo_cnt #(.CNT_W(CNT_W)) u_tmo (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (char_done),
    .load_val  (tmo_val),
    .idle_char (idle_char),
    .fire      (fire)
  );

  always_comb begin
    close_d = fire;
    irq_d   = fire && irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      close_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      close_q <= close_d;
      irq_q   <= irq_d;
    end
  end

  assign close_o = close_q;
  assign irq_o   = irq_q;

  assert_irq_with_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> close_o);
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    close_o |=> !close_o);
  assert_close_follows_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> close_o);
endmodule

// File: tb/uart_idle_timeout_tb.sv
module uart_idle_timeout_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         bit_stb, rx_line, char_done;
  logic         data8, addr_en, par_en, stop2, irq_en;
  logic [W-1:0] tmo_val;
  logic         close_o, irq_o;

  int checks = 0, failures = 0;
  int nclose = 0, nirq = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  int run = 0, rem = 0, armed = 0, exp_close = 0, exp_irq = 0, mlen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_idle_timeout #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .rx_line(rx_line),
    .char_done(char_done), .data8(data8), .addr_en(addr_en), .par_en(par_en),
    .stop2(stop2), .tmo_val(tmo_val), .irq_en(irq_en),
    .close_o(close_o), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      run = 0; rem = 0; armed = 0; exp_close = 0; exp_irq = 0;
    end else begin
      mlen = 1 + (data8 ? 8 : 7) + int'(addr_en) + int'(par_en) + (stop2 ? 2 : 1);
      exp_close = 0; exp_irq = 0;
      if (char_done) begin
        run = 0;
        rem = (tmo_val == 0) ? (1 << W) : int'(tmo_val);
        armed = 1;
      end else if (bit_stb) begin
        if (!rx_line) run = 0;
        else begin
          run++;
          if (run >= mlen) begin
            run = 0;
            if (armed != 0) begin
              rem--;
              if (rem == 0) begin
                exp_close = 1; exp_irq = int'(irq_en); armed = 0;
              end
            end
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      check(close_o === exp_close[0], {cur_req, " close_o"}, int'(close_o), exp_close);
      check(irq_o === exp_irq[0], {cur_req, " irq_o"}, int'(irq_o), exp_irq);
      if (close_o === 1'b1) nclose++;
      if (irq_o === 1'b1) nirq++;
    end
  end

  task automatic step(input logic s, input logic r, input logic cd);
    @(posedge clk); #1;
    bit_stb = s; rx_line = r; char_done = cd;
  endtask

  task automatic ones(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b0);
  endtask

  task automatic settle();
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
  endtask

  task automatic set_fmt(input logic d8, input logic a, input logic p, input logic s2);
    data8 = d8; addr_en = a; par_en = p; stop2 = s2;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      failures++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bit_stb = 1'b0; rx_line = 1'b1; char_done = 1'b0;
    set_fmt(1'b0, 1'b0, 1'b0, 1'b0); tmo_val = W'(2); irq_en = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check(close_o === 1'b0 && irq_o === 1'b0, "R1 reset outputs", int'(close_o), 0);
    @(posedge clk); #1; rst_n = 1'b1;

    // R1: idle line before any data character never times out
    cur_req = "R1";
    ones(60); settle();
    check(nclose == 0, "R1 no timeout unarmed", nclose, 0);

    // R5/R2: 9-bit characters, two idle chars
    cur_req = "R5";
    step(1'b0, 1'b1, 1'b1);
    ones(17); settle();
    check(nclose == 0, "R5 one bit short", nclose, 0);
    ones(1); settle();
    check(nclose == 1, "R5 timeout fires", nclose, 1);
    check(nirq == 1, "R8 irq with enable", nirq, 1);

    // R7: no second timeout in the same gap
    cur_req = "R7";
    ones(45); settle();
    check(nclose == 1, "R7 single per gap", nclose, 1);

    // R3/R2: 13-bit characters, a zero restarts the run
    cur_req = "R3";
    set_fmt(1'b1, 1'b1, 1'b1, 1'b1); tmo_val = W'(1);
    step(1'b0, 1'b1, 1'b1);
    ones(12); step(1'b1, 1'b0, 1'b0); ones(12); settle();
    check(nclose == 1, "R3 zero restarts run", nclose, 1);
    ones(1); settle();
    check(nclose == 2, "R2 13-bit idle char", nclose, 2);

    // R9: no strobe means no sample
    cur_req = "R9";
    set_fmt(1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    ones(8);
    for (int i = 0; i < 10; i++) step(1'b0, i[0], 1'b0);
    settle();
    check(nclose == 2, "R9 unstrobed zeros ignored", nclose, 2);
    ones(1); settle();
    check(nclose == 3, "R9 run kept across gaps", nclose, 3);

    // R8: interrupt disabled
    cur_req = "R8";
    irq_en = 1'b0;
    step(1'b0, 1'b1, 1'b1);
    ones(9); settle();
    check(nclose == 4, "R8 close without irq", nclose, 4);
    check(nirq == 3, "R8 irq gated off", nirq, 3);
    irq_en = 1'b1;

    // R10: char_done wins over a simultaneous strobe
    cur_req = "R10";
    step(1'b1, 1'b1, 1'b1);
    ones(8); settle();
    check(nclose == 4, "R10 strobe discarded", nclose, 4);
    ones(1); settle();
    check(nclose == 5, "R10 count after reload", nclose, 5);

    // R4: a new character mid-gap reloads the counter
    cur_req = "R4";
    tmo_val = W'(3);
    step(1'b0, 1'b1, 1'b1);
    ones(18);
    step(1'b0, 1'b1, 1'b1);
    ones(18); settle();
    check(nclose == 5, "R4 reload discards count", nclose, 5);
    ones(9); settle();
    check(nclose == 6, "R4 timeout after reload", nclose, 6);

    // R2: 11-bit characters
    cur_req = "R2";
    set_fmt(1'b1, 1'b0, 1'b1, 1'b0); tmo_val = W'(2);
    step(1'b0, 1'b1, 1'b1);
    ones(21); settle();
    check(nclose == 6, "R2 11-bit one short", nclose, 6);
    ones(1); settle();
    check(nclose == 7, "R2 11-bit timeout", nclose, 7);

    // R6: zero means 2^W
    cur_req = "R6";
    set_fmt(1'b0, 1'b0, 1'b0, 1'b0); tmo_val = '0;
    step(1'b0, 1'b1, 1'b1);
    ones(255 * 9); settle();
    check(nclose == 7, "R6 not before 256", nclose, 7);
    ones(9); settle();
    check(nclose == 8, "R6 fires at 256", nclose, 8);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule